// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a dual-rail data bus of `WIDTH` bit positions and reports when the bus has finished a transition, so that the result can serve as the acknowledge of a four-phase handshake. Each rail pair is first reduced to one validity term: an OR of its two rails when the bus idles at all zeros, and an AND when it idles at all ones. A balanced tree of two-input C-elements then merges those terms into one `done` signal. A C-element changes its output only when both of its inputs agree. Because of this, the tree keeps its last decision while the bus is part way between the data state and the idle state.

The idle polarity is chosen at elaboration by a parameter. `done` has the same meaning in both polarities: it is 1 once every pair carries a data code and 0 once every pair has returned to the idle code. Each C-element is modelled as a combinational majority of its two inputs and a stored copy of its own output. The stored copy is updated on every clock edge and is forced to the idle level by a synchronous active-low reset. A change on the bus therefore reaches `done` within the same cycle, and the clock edge commits it as history. `WIDTH` need not be a power of two: unused tree leaves repeat bit 0, which leaves the merge result unchanged.

Top module: `dr_done_detect`

## Requirements
- R1: With `SPACER = SPACER_ZERO`, a pair encodes logical 1 as rail1=1/rail0=0 and logical 0 as rail1=0/rail0=1. When every pair carries such a code, `done` is 1 in that same cycle, whatever the data values.
- R2: With `SPACER = SPACER_ZERO`, the idle code is rail1=0/rail0=0. When every pair is idle, `done` is 0 in that same cycle.
- R3: With `SPACER = SPACER_ONE`, a pair encodes logical 1 as rail1=0/rail0=1 and logical 0 as rail1=1/rail0=0. When every pair carries such a code, `done` is 1 in that same cycle.
- R4: With `SPACER = SPACER_ONE`, the idle code is rail1=1/rail0=1. When every pair is idle, `done` is 0 in that same cycle.
- R5: While the bus mixes data pairs and idle pairs, `done` keeps the value it had in the previous cycle. This holds in either direction of travel and whichever pairs arrive first.
- R6: `done` goes from 0 to 1 only in a cycle where every pair carries data. It goes from 1 to 0 only in a cycle where every pair is idle.
- R7: A clock edge with `rst_n` low sets every stored C-element state to the idle level. After that edge, a mixed bus gives `done` = 0.
- R8: A `WIDTH` that is not a power of two behaves as in R1 to R6. Every real pair still gates both edges of `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that commits the C-element states |
| rst_n | input | 1 | Synchronous active-low reset to the idle level |
| rail1 | input | WIDTH | Rail 1 of each bit pair |
| rail0 | input | WIDTH | Rail 0 of each bit pair |
| done | output | 1 | 1 after a complete data wave, 0 after a complete idle wave |

## Verification
The bound checker compares `done` on every cycle with the bus as seen at the ports. It checks that a full data wave forces `done` high and a full idle wave forces it low. It checks that `done` holds steady through any mixed state, and that each edge of `done` occurs only in a cycle with a complete wave. The bench scenarios show what those per-cycle checks cannot: data arriving in staggered orders, idle codes returning in staggered orders, the padded five-bit tree in the all-ones idle polarity, and a reset taken while the bus is only partly valid.

// File: rtl/dr_pkg.sv
// Package: shared types for the dual-rail completion detector.
// Assumes: nothing beyond IEEE 1800-2017.
package dr_pkg;

    // Idle (spacer) polarity of the dual-rail bus.
    typedef enum logic {
        SPACER_ZERO = 1'b0,
        SPACER_ONE  = 1'b1
    } spacer_e;

endpackage

// File: rtl/dr_celem.sv
// Module: two-input C-element. The output follows the inputs when they agree
// and otherwise repeats the stored level. The stored level is committed on
// each clock edge.
// Assumes: inputs are stable around the clock edge; rst_n is synchronous.
module dr_celem #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic y
);

    logic held;

    // Majority of both inputs and the stored output.
    always_comb begin
        y = (a & b) | ((a | b) & held);
    end

    // Commit the current output as history; reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= RESET_VAL;
        end else begin
            held <= y;
        end
    end

endmodule

// File: rtl/dr_pair_reduce.sv
// Module: reduces each rail pair to one validity term. Zero idle uses OR,
// so data gives 1. One idle uses AND, so data gives 0.
// Assumes: the sender never drives the illegal code of the chosen polarity.
module dr_pair_reduce
    import dr_pkg::*;
#(
    parameter int      WIDTH  = 8,
    parameter spacer_e SPACER = SPACER_ZERO
) (
    input  logic [WIDTH-1:0] rail1,
    input  logic [WIDTH-1:0] rail0,
    output logic [WIDTH-1:0] term
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        if (SPACER == SPACER_ZERO) begin : g_or
            // Any raised rail marks data on this pair.
            assign term[i] = rail1[i] | rail0[i];
        end else begin : g_and
            // Any lowered rail marks data on this pair.
            assign term[i] = rail1[i] & rail0[i];
        end
    end

endmodule

// File: rtl/dr_ctree.sv
// Module: balanced tree of two-input C-elements in heap order. Node i has
// children 2i+1 and 2i+2, and the leaves sit at indices LEAVES-1 .. 2*LEAVES-2.
// Unused leaves repeat input 0, which leaves the merge unchanged.
// Assumes: WIDTH >= 1.
module dr_ctree #(
    parameter int   WIDTH     = 8,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] leaf_in,
    output logic             root
);

    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node;

    // Leaf layer: real terms, then padding copies of term 0.
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < WIDTH) begin : g_real
            assign node[LEAVES-1+j] = leaf_in[j];
        end else begin : g_pad
            assign node[LEAVES-1+j] = leaf_in[0];
        end
    end

    // Internal layer: one C-element per inner node.
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        dr_celem #(.RESET_VAL(RESET_VAL)) u_cel (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (node[2*k+1]),
            .b     (node[2*k+2]),
            .y     (node[k])
        );
    end

    assign root = node[0];

endmodule

// File: rtl/dr_done_detect.sv
// Module: top of the completion detector. Per-pair reduction, C-element
// tree, then a polarity fix so that done = 1 means "whole bus holds data"
// in both idle polarities.
// Assumes: synchronous active-low reset taken while the bus is idle or mixed.
module dr_done_detect
    import dr_pkg::*;
#(
    parameter int      WIDTH  = 8,
    parameter spacer_e SPACER = SPACER_ZERO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail1,
    input  logic [WIDTH-1:0] rail0,
    output logic             done
);

    localparam logic IDLE_TERM = (SPACER == SPACER_ONE) ? 1'b1 : 1'b0;

    logic [WIDTH-1:0] term;
    logic             root;

    dr_pair_reduce #(.WIDTH(WIDTH), .SPACER(SPACER)) u_reduce (
        .rail1 (rail1),
        .rail0 (rail0),
        .term  (term)
    );

    dr_ctree #(.WIDTH(WIDTH), .RESET_VAL(IDLE_TERM)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .leaf_in (term),
        .root    (root)
    );

    // Map the tree level onto the data-complete sense of done.
    always_comb begin
        done = root ^ IDLE_TERM;
    end

endmodule

// File: rtl/dr_done_detect_chk.sv
// Module: checker for dr_done_detect. It relates done to the port-level bus
// state on every clock.
// Assumes: bound into each instance of dr_done_detect.
module dr_done_detect_chk
    import dr_pkg::*;
#(
    parameter int      WIDTH  = 8,
    parameter spacer_e SPACER = SPACER_ZERO
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] rail1,
    input logic [WIDTH-1:0] rail0,
    input logic             done
);

    logic all_data;
    logic all_idle;

    // Classify the bus from the rails alone.
    always_comb begin
        all_data = &(rail1 ^ rail0);
        if (SPACER == SPACER_ZERO) begin
            all_idle = ~|(rail1 | rail0);
        end else begin
            all_idle = &(rail1 & rail0);
        end
    end

    // R1, R3
    full_data_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_data |-> done);

    // R2, R4
    full_idle_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_idle |-> !done);

    // R5
    mixed_holds_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_data && !all_idle) |-> $stable(done));

    // R6
    rise_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> all_data);

    // R6
    fall_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> all_idle);

endmodule

bind dr_done_detect dr_done_detect_chk #(.WIDTH(WIDTH), .SPACER(SPACER)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rail1 (rail1),
    .rail0 (rail0),
    .done  (done)
);

// File: tb/dr_done_detect_tb.sv
module dr_done_detect_tb;
    import dr_pkg::*;

    localparam int W8 = 8;
    localparam int W5 = 5;

    typedef struct packed {
        logic [7:0] mask;   // 1 = pair carries data, 0 = pair idle
        logic [7:0] value;  // data bit per pair
        logic       exp8;   // expected done, zero-idle, 8 pairs
        logic       exp5;   // expected done, one-idle, 5 pairs (mask[4:0])
    } step_t;

    localparam int NSTEP = 12;
    localparam step_t TABLE [NSTEP] = '{
        '{8'h00, 8'hA5, 1'b0, 1'b0},  // R2 R4 idle
        '{8'h01, 8'h3C, 1'b0, 1'b0},  // R5 first pair arrives
        '{8'h0F, 8'hF0, 1'b0, 1'b0},  // R5 half data
        '{8'h1F, 8'h0F, 1'b0, 1'b1},  // R3 R8 five-bit bus complete
        '{8'hFF, 8'h55, 1'b1, 1'b1},  // R1 full data
        '{8'hF0, 8'hAA, 1'b1, 1'b1},  // R5 low pairs idle first
        '{8'h80, 8'h96, 1'b1, 1'b0},  // R4 R5 one-idle bus fully idle
        '{8'h00, 8'h69, 1'b0, 1'b0},  // R2 full idle
        '{8'hFE, 8'h01, 1'b0, 1'b0},  // R6 R8 pair 0 missing blocks rise
        '{8'hFF, 8'hFE, 1'b1, 1'b1},  // R1 R3 rise
        '{8'h7F, 8'h80, 1'b1, 1'b1},  // R6 top pair idle first
        '{8'h00, 8'h7F, 1'b0, 1'b0}   // R2 R4 fall
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W8-1:0] z_r1 = '0, z_r0 = '0;
    logic [W5-1:0] o_r1 = '1, o_r0 = '1;
    logic          z_done, o_done;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dr_done_detect #(.WIDTH(W8), .SPACER(SPACER_ZERO)) u_dut (
        .clk(clk), .rst_n(rst_n), .rail1(z_r1), .rail0(z_r0), .done(z_done));

    dr_done_detect #(.WIDTH(W5), .SPACER(SPACER_ONE)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .rail1(o_r1), .rail0(o_r0), .done(o_done));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Encode both buses from one mask/value pair and flag illegal codes.
    task automatic drive(input logic [7:0] mask, input logic [7:0] value);
        for (int i = 0; i < W8; i++) begin
            z_r1[i] = mask[i] &  value[i];
            z_r0[i] = mask[i] & ~value[i];
            check("R1 zero-idle code legal", z_r1[i] & z_r0[i], 1'b0);
        end
        for (int i = 0; i < W5; i++) begin
            o_r1[i] = ~(mask[i] &  value[i]);
            o_r0[i] = ~(mask[i] & ~value[i]);
            check("R3 one-idle code legal", o_r1[i] | o_r0[i], 1'b1);
        end
    endtask

    initial begin
        drive(8'h00, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R7 reset state zero-idle", z_done, 1'b0);
        check("R7 reset state one-idle", o_done, 1'b0);

        // Table walk: drive at the falling edge, sample 5 ns later.
        for (int s = 0; s < NSTEP; s++) begin
            @(negedge clk);
            drive(TABLE[s].mask, TABLE[s].value);
            #5;
            check("R1/R2/R5/R6 zero-idle step", z_done, TABLE[s].exp8);
            check("R3/R4/R5/R8 one-idle step", o_done, TABLE[s].exp5);
        end

        // R5: a long mixed hold after full data keeps done high.
        @(negedge clk);
        drive(8'hFF, 8'h33);
        repeat (4) begin
            @(negedge clk);
            drive(8'h5A, 8'hC3);
            #5;
            check("R5 hold high zero-idle", z_done, 1'b1);
            check("R5 hold high one-idle", o_done, 1'b1);
        end

        // R7: reset taken with a mixed bus clears the stored state.
        @(negedge clk);
        drive(8'hFF, 8'h00);
        #5;
        check("R1 full data before reset", z_done, 1'b1);
        @(negedge clk);
        drive(8'h0F, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        #5;
        check("R7 mixed bus after reset edge zero-idle", z_done, 1'b0);
        check("R7 mixed bus after reset edge one-idle", o_done, 1'b0);
        drive(8'h00, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive(8'h0F, 8'h00);
        #5;
        check("R7 mixed bus held low after release", z_done, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule